// File: doc/BRIEF.md
# Write-Busy Status Bit Generator

This block sits on the device side of a byte-wide memory port. It decides what a host sees when it reads the part while an internal write is still running. A byte is loaded while chip-select and the write strobe are both low. The internal write begins once either strobe returns high. At that moment the byte and its address are committed to a small register array, and a busy timer starts.

For the length of the busy period, reads do not return array contents. They return a status byte built from the last loaded byte and one toggle flip-flop. Bit 7 carries the inverse of the loaded bit 7, so a poller can compare it against the value it wrote. Bit 6 flips once per read access, so two reads in a row differ. When the timer runs out, reads return the stored data and bit 6 stops changing. Write attempts made during the busy period are discarded.

All strobes are active low and sampled on the rising edge of `clk`. A read access starts at the first edge at which both chip-select and output-enable are seen low after not being so.

Top module: `write_busy_status`

## Requirements
- R1: After reset `busy` is 0, `rdata` is 0x00, and every array location reads back 0x00.
- R2: A byte and address are captured while `ce_n` and `we_n` are both low. The internal write starts at the first clock edge at which either of them is seen high again. `busy` goes high after that edge, and not while both strobes remain low.
- R3: `busy` stays high for exactly `BUSY_CYCLES` clock cycles per accepted write.
- R4: While `busy` is high, a read returns the latched byte with bit 7 inverted, whatever address is presented. Bits 5..0 are the latched bits 5..0.
- R5: While `busy` is high, bit 6 of read data flips on each new read access. The first read access after a write starts returns bit 6 = 1. Holding a read over several cycles counts as one access.
- R6: While `busy` is low, a read returns the byte stored at `addr`, and repeated reads return the same value.
- R7: A write attempted while `busy` is high changes nothing. The array is untouched, the latched status byte is unchanged, and the busy period is not extended.
- R8: `rdata` is registered. It is updated only at the edge that starts a read access and holds its value in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 8 | Byte being loaded |
| rdata | output | 8 | Read data: status byte while busy, stored byte otherwise |
| busy | output | 1 | High while the modelled internal write is running |

## Verification
The embedded assertions watch, on every cycle, four things:
- `busy` rises after an accepted write ends.
- The timer never runs past its count, and `busy` falls when the count reaches zero.
- The latched byte is frozen during busy, and a busy read inverts bit 7.
- Ready reads return the addressed array word, and `rdata` only moves at the start of a read access.

The bit-6 sequence can only be shown by the directed scenarios. These cover the first read returning 1, held reads not flipping, and the toggle restarting for each new write. The scenarios also show which strobe ends a write, the exact busy length measured at the port, and that a discarded write leaves no trace in later reads.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

    localparam int BYTE_W     = 8;
    localparam int POLL_BIT   = 7;
    localparam int TOGGLE_BIT = 6;

    typedef logic [BYTE_W-1:0] byte_t;

    // Status byte shown while the internal write runs.
    function automatic byte_t status_byte(input byte_t loaded, input logic tog);
        byte_t s;
        s             = loaded;
        s[POLL_BIT]   = ~loaded[POLL_BIT];
        s[TOGGLE_BIT] = tog;
        return s;
    endfunction

endpackage

// File: rtl/wbs_strobe_sense.sv
module wbs_strobe_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    output logic wr_hold,
    output logic wr_end,
    output logic rd_start
);

    typedef struct packed {
        logic wr;
        logic rd;
    } sense_t;

    sense_t s_d, s_q;

    always_comb begin
        s_d.wr   = !ce_n && !we_n;
        s_d.rd   = !ce_n && !oe_n;
        wr_hold  = s_d.wr;
        wr_end   = s_q.wr && !s_d.wr;   // first strobe to rise ends the load
        rd_start = s_d.rd && !s_q.rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/wbs_byte_latch.sv
module wbs_byte_latch
    import wbs_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr_i,
    input  byte_t             data_i,
    output logic [ADDR_W-1:0] lat_addr,
    output byte_t             lat_data
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        byte_t             data;
    } latch_t;

    latch_t l_d, l_q;

    always_comb begin
        l_d = l_q;
        if (capture) begin
            l_d.addr = addr_i;
            l_d.data = data_i;
        end
        lat_addr = l_q.addr;
        lat_data = l_q.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

endmodule

// File: rtl/wbs_busy_timer.sv
module wbs_busy_timer #(
    parameter int BUSY_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BUSY_CYCLES - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } timer_t;

    timer_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (t_q.busy) begin
            if (t_q.cnt == '0) t_d.busy = 1'b0;
            else               t_d.cnt  = t_q.cnt - 1'b1;
        end else if (start) begin
            t_d.busy = 1'b1;
            t_d.cnt  = LAST;
        end
        busy = t_q.busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assert_busy_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.busy && t_q.cnt == '0 |=> !t_q.busy);

    assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.busy |-> t_q.cnt <= LAST);

endmodule

// File: rtl/write_busy_status.sv
module write_busy_status
    import wbs_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int BUSY_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              busy
);

    localparam int DEPTH = 1 << ADDR_W;

    logic              wr_hold, wr_end, rd_start;
    logic              capture, commit;
    logic [ADDR_W-1:0] lat_addr;
    byte_t             lat_data;
    byte_t             mem_q [DEPTH];

    wbs_strobe_sense i_sense (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .wr_hold  (wr_hold),
        .wr_end   (wr_end),
        .rd_start (rd_start)
    );

    // Loads and commits are both blocked for the whole busy period.
    assign capture = wr_hold && !busy;
    assign commit  = wr_end && !busy;

    wbs_byte_latch #(.ADDR_W(ADDR_W)) i_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .addr_i   (addr),
        .data_i   (wdata),
        .lat_addr (lat_addr),
        .lat_data (lat_data)
    );

    wbs_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (commit),
        .busy  (busy)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (commit) begin
            mem_q[lat_addr] <= lat_data;
        end
    end

    typedef struct packed {
        logic  tog;
        byte_t rdata;
    } rd_t;

    rd_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (commit) begin
            r_d.tog = 1'b0;           // next busy read shows 1
        end else if (rd_start) begin
            if (busy) begin
                r_d.tog   = ~r_q.tog;
                r_d.rdata = status_byte(lat_data, ~r_q.tog);
            end else begin
                r_d.rdata = mem_q[addr];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rdata = r_q.rdata;

    assert_busy_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_end && !busy |=> busy);

    assert_poll_inverse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start && busy |=> rdata[POLL_BIT] != lat_data[POLL_BIT]);

    assert_ready_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start && !busy && !wr_end |=> rdata == $past(mem_q[addr]));

    assert_latch_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(lat_data) && $stable(lat_addr));

    assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_start |=> $stable(rdata));

endmodule

// File: tb/test_write_busy_status.sv
`timescale 1ns/1ps
module test_write_busy_status;

    localparam int ADDR_W = 4;
    localparam int NBUSY  = 40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        wdata = '0;
    logic [7:0]        rdata;
    logic              busy;

    int errors = 0;
    int checks = 0;
    int cyc = 0, busy_from = 0, busy_len = -1;
    logic busy_prev = 1'b0;

    always #4 clk = ~clk;

    write_busy_status #(.ADDR_W(ADDR_W), .BUSY_CYCLES(NBUSY)) i_write_busy_status (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
    );

    // Measures each busy period at the port, in cycles.
    always @(negedge clk) begin
        cyc++;
        if (busy && !busy_prev) busy_from = cyc;
        if (!busy && busy_prev) busy_len = cyc - busy_from;
        busy_prev = busy;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // ce_first=1 releases chip-select first, otherwise the write strobe.
    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                            input bit ce_first, input bit expect_start);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        if (expect_start) check("R2 busy low while strobes held", busy, 0);
        if (ce_first) ce_n = 1'b1; else we_n = 1'b1;
        @(negedge clk);
        if (expect_start) check("R2 busy after first strobe rises", busy, 1);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a, input int hold,
                           output logic [7:0] d);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; addr = a;
        @(negedge clk);
        d = rdata;
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            check("R8 rdata held during one access", rdata, d);
        end
        oe_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic wait_ready();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 busy after reset", busy, 0);
        check("R1 rdata after reset", rdata, 8'h00);
        do_read(4'd7, 0, d);
        check("R1 array cleared", d, 8'h00);
    endtask

    task automatic t_we_first();
        do_write(4'd3, 8'hA5, 1'b0, 1'b1);
        wait_ready();
        check("R3 busy length", busy_len, NBUSY);
    endtask

    task automatic t_ready_reads();
        logic [7:0] d;
        do_read(4'd3, 2, d);
        check("R6 stored byte", d, 8'hA5);
        do_read(4'd3, 0, d);
        check("R6 repeated read same", d, 8'hA5);
        @(negedge clk);
        check("R8 rdata held after access", rdata, 8'hA5);
    endtask

    task automatic t_busy_status();
        logic [7:0] d;
        busy_len = -1;
        do_write(4'd5, 8'h3C, 1'b1, 1'b1);
        do_read(4'd5, 3, d);
        check("R4/R5 first busy read", d, 8'hFC);
        do_read(4'd0, 0, d);
        check("R4/R5 second read other address", d, 8'hBC);
        do_read(4'd5, 0, d);
        check("R5 third read", d, 8'hFC);
        do_write(4'd9, 8'hFF, 1'b0, 1'b0);   // dropped
        check("R7 busy still high", busy, 1);
        do_read(4'd9, 0, d);
        check("R7 status byte unchanged", d, 8'hBC);
        wait_ready();
        check("R7 busy not extended", busy_len, NBUSY);
        do_read(4'd9, 0, d);
        check("R7 dropped write not stored", d, 8'h00);
        do_read(4'd5, 0, d);
        check("R6 ready data", d, 8'h3C);
    endtask

    task automatic t_toggle_restart();
        logic [7:0] d;
        do_write(4'd3, 8'h40, 1'b0, 1'b1);
        do_read(4'd3, 0, d);
        check("R5 first read after new write", d, 8'hC0);
        do_read(4'd3, 0, d);
        check("R5 second read flips", d, 8'h80);
        wait_ready();
        do_read(4'd3, 0, d);
        check("R6 true data after busy", d, 8'h40);
        do_read(4'd3, 0, d);
        check("R6 no toggle after busy", d, 8'h40);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_we_first();
        t_ready_reads();
        t_busy_status();
        t_toggle_restart();
        finish_run();
    end

endmodule